// File: doc/BRIEF.md
# Interval Log Record Encoder

This block turns a stream of counted instructions, delivered in program order, into the log entries of one execution interval. Each counted instruction comes with a class. In-order instructions only advance a running count and produce no entry. Reordered loads and reordered stores produce typed entries, and each is preceded by an in-order block entry that holds the count gathered so far, whenever that count is nonzero. The block counts every instruction that arrives with the in-order class, whether or not it touched memory.

When the processor exchanges data with another processor, a separate request closes the current interval. Any pending count is written out, followed by an end marker that carries the number of the closing interval. The interval number then advances, and the block exports it so that producers can stamp each perform event with it. Entries leave the block on a valid/ready stream. New input is accepted only when no entry is waiting.

Top module: `interval_log_encoder`

## Requirements
- R1: After reset, `log_valid` is 0, `in_ready` is 1 and `cur_isn` is 0, and the running count is zero.
- R2: An accepted count with class 0 (in-order) adds one to the running count and emits no entry.
- R3: An accepted count with class 1 (reordered load) emits, in this order, a block entry holding the running count (if it is nonzero) and a reordered-load entry whose payload bits [DATA_W-1:0] carry `cnt_value`. The running count then returns to zero.
- R4: A running count of zero is never emitted as a block entry, neither before a reordered entry nor at interval end.
- R5: An accepted count with class 2 (reordered store) emits the pending block entry as in R3, then a reordered-store entry. Its payload is {address, data, offset}, with the offset in the low ISN_W bits. The offset equals `cur_isn - cnt_pisn` modulo 2^ISN_W.
- R6: An accepted `iend_req` emits the pending nonzero block entry, then an end marker whose payload low bits carry the closing interval number. `cur_isn` then increments and the running count clears.
- R7: Bits [ENT_W-1:ENT_W-2] of every entry hold the type: 0 block, 1 reordered load, 2 reordered store, 3 interval end. Payload bits that a type does not use are zero. A block entry carries its count in the low CNT_W bits.
- R8: An entry with `log_valid` high and `log_ready` low stays valid and unchanged. `in_ready` is low whenever any entry is waiting.
- R9: When `iend_req` and `cnt_valid` are both high in a cycle where `in_ready` is high, the interval end is taken and the count waits. The count then belongs to the next interval.
- R10: When the running count reaches 2^CNT_W-1, a block entry holding 2^CNT_W-1 is emitted and the count restarts at zero.
- R11: An accepted count with class 3 is consumed and has no effect: it emits no entry and leaves the running count unchanged.
- R12: Entries leave the block in the order the instructions and interval ends were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_valid | input | 1 | A counted instruction is offered |
| cnt_class | input | 2 | 0 in-order, 1 reordered load, 2 reordered store, 3 no effect |
| cnt_value | input | DATA_W | Value the load returned or the store wrote |
| cnt_addr | input | ADDR_W | Address the store wrote to |
| cnt_pisn | input | ISN_W | Interval number stamped at the perform event |
| iend_req | input | 1 | Request to close the current interval |
| in_ready | output | 1 | Count or interval end is accepted this cycle |
| log_valid | output | 1 | Log entry available |
| log_ready | input | 1 | Consumer takes the entry |
| log_entry | output | ENT_W | Typed log entry, type in the two top bits |
| cur_isn | output | ISN_W | Number of the current interval |

## Verification
The assertions check the following on every cycle:
- A stalled entry stays held.
- A queued second entry never sits behind an empty head.
- No block entry carries a zero count.
- The interval number steps by one on each accepted end.
- A class-3 count never raises `log_valid`.
- The running count steps by one per in-order instruction.

Other properties are only visible in the bench's scenarios, which compare the full entry sequence with an independent model:
- The exact payload values, including store offsets that wrap around the interval number.
- The ordering of block entries ahead of reordered entries.
- The flush at the count limit.
- The handling of an end request and a count that arrive in the same cycle.

// File: rtl/irle_pkg.sv
package irle_pkg;

  typedef enum logic [1:0] {
    ENT_BLOCK  = 2'd0,
    ENT_RLOAD  = 2'd1,
    ENT_RSTORE = 2'd2,
    ENT_IEND   = 2'd3
  } ent_kind_e;

  typedef enum logic [1:0] {
    CLS_INORDER = 2'd0,
    CLS_RLOAD   = 2'd1,
    CLS_RSTORE  = 2'd2,
    CLS_NONE    = 2'd3
  } cnt_class_e;

endpackage

// File: rtl/irle_run_counter.sv
module irle_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] run,
  output logic             wrap_evt
);

  localparam logic [CNT_W-1:0] LAST = '1;
  localparam logic [CNT_W-1:0] PRE_LAST = LAST - 1'b1;

  // the increment that would reach the limit flushes instead
  assign wrap_evt = inc && (run == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0;
    end else if (clr) begin
      run <= '0;
    end else if (inc) begin
      run <= wrap_evt ? '0 : run + 1'b1;
    end
  end

  // R2
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !wrap_evt) |=> (run == $past(run) + 1'b1));

  // R10
  run_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run != LAST);

endmodule

// File: rtl/irle_entry_former.sv
module irle_entry_former
  import irle_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ISN_W  = 8,
  parameter int CNT_W  = 16,
  localparam int PAY_W = ADDR_W + DATA_W + ISN_W,
  localparam int ENT_W = 2 + PAY_W
) (
  input  logic              do_io,
  input  logic              do_rl,
  input  logic              do_rs,
  input  logic              do_end,
  input  logic              wrap_evt,
  input  logic [CNT_W-1:0]  run,
  input  logic [ISN_W-1:0]  cisn,
  input  logic [DATA_W-1:0] value,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ISN_W-1:0]  pisn,
  output logic              ld,
  output logic [ENT_W-1:0]  e0,
  output logic              e1_v,
  output logic [ENT_W-1:0]  e1
);

  localparam logic [CNT_W-1:0] LAST = '1;

  function automatic logic [ISN_W-1:0] f_offset(logic [ISN_W-1:0] cur, logic [ISN_W-1:0] perf);
    return cur - perf;
  endfunction

  function automatic logic [ENT_W-1:0] f_block(logic [CNT_W-1:0] cnt);
    return {ENT_BLOCK, PAY_W'(cnt)};
  endfunction

  function automatic logic [ENT_W-1:0] f_rload(logic [DATA_W-1:0] v);
    return {ENT_RLOAD, PAY_W'(v)};
  endfunction

  function automatic logic [ENT_W-1:0] f_rstore(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                                               logic [ISN_W-1:0] o);
    return {ENT_RSTORE, a, d, o};
  endfunction

  function automatic logic [ENT_W-1:0] f_iend(logic [ISN_W-1:0] isn);
    return {ENT_IEND, PAY_W'(isn)};
  endfunction

  logic             has_run;
  logic             closing;
  logic [ENT_W-1:0] special;

  assign has_run = (run != '0);
  assign closing = do_rl || do_rs || do_end;

  always_comb begin
    if (do_rl)      special = f_rload(value);
    else if (do_rs) special = f_rstore(addr, value, f_offset(cisn, pisn));
    else            special = f_iend(cisn);
  end

  always_comb begin
    ld   = 1'b0;
    e0   = '0;
    e1_v = 1'b0;
    e1   = '0;
    if (do_io && wrap_evt) begin
      ld = 1'b1;
      e0 = f_block(LAST);
    end else if (closing) begin
      ld = 1'b1;
      if (has_run) begin
        e0   = f_block(run);
        e1_v = 1'b1;
        e1   = special;
      end else begin
        e0 = special;
      end
    end
  end

endmodule

// File: rtl/irle_out_stage.sv
module irle_out_stage #(
  parameter int ENT_W = 106
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [ENT_W-1:0] e0,
  input  logic             e1_v,
  input  logic [ENT_W-1:0] e1,
  input  logic             log_ready,
  output logic             log_valid,
  output logic [ENT_W-1:0] log_entry,
  output logic             idle
);

  logic             head_v, tail_v;
  logic [ENT_W-1:0] head, tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_v <= 1'b0;
      tail_v <= 1'b0;
      head   <= '0;
      tail   <= '0;
    end else if (ld) begin
      head_v <= 1'b1;
      head   <= e0;
      tail_v <= e1_v;
      tail   <= e1;
    end else if (head_v && log_ready) begin
      head_v <= tail_v;
      head   <= tail;
      tail_v <= 1'b0;
    end
  end

  assign log_valid = head_v;
  assign log_entry = head;
  assign idle      = !head_v && !tail_v;

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_v && !log_ready) |=> (head_v && $stable(head)));

  // R12
  tail_behind_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_v |-> head_v);

  // R8
  load_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !head_v);

endmodule

// File: rtl/interval_log_encoder.sv
module interval_log_encoder
  import irle_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ISN_W  = 8,
  parameter int CNT_W  = 16,
  localparam int ENT_W = 2 + ADDR_W + DATA_W + ISN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_valid,
  input  logic [1:0]        cnt_class,
  input  logic [DATA_W-1:0] cnt_value,
  input  logic [ADDR_W-1:0] cnt_addr,
  input  logic [ISN_W-1:0]  cnt_pisn,
  input  logic              iend_req,
  output logic              in_ready,
  output logic              log_valid,
  input  logic              log_ready,
  output logic [ENT_W-1:0]  log_entry,
  output logic [ISN_W-1:0]  cur_isn
);

  logic             idle;
  logic             acc_end, acc_cnt;
  logic             do_io, do_rl, do_rs, do_nop;
  logic             wrap_evt;
  logic [CNT_W-1:0] run;
  logic             ld, e1_v;
  logic [ENT_W-1:0] e0, e1;
  cnt_class_e       cls;

  assign cls      = cnt_class_e'(cnt_class);
  assign in_ready = idle;
  // an interval end outranks a count offered in the same cycle
  assign acc_end  = iend_req && idle;
  assign acc_cnt  = cnt_valid && idle && !iend_req;
  assign do_io    = acc_cnt && (cls == CLS_INORDER);
  assign do_rl    = acc_cnt && (cls == CLS_RLOAD);
  assign do_rs    = acc_cnt && (cls == CLS_RSTORE);
  assign do_nop   = acc_cnt && (cls == CLS_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)       cur_isn <= '0;
    else if (acc_end) cur_isn <= cur_isn + 1'b1;
  end

  irle_run_counter #(.CNT_W(CNT_W)) run_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (do_io),
    .clr      (acc_end || do_rl || do_rs),
    .run      (run),
    .wrap_evt (wrap_evt)
  );

  irle_entry_former #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ISN_W(ISN_W), .CNT_W(CNT_W)
  ) form_i (
    .do_io    (do_io),
    .do_rl    (do_rl),
    .do_rs    (do_rs),
    .do_end   (acc_end),
    .wrap_evt (wrap_evt),
    .run      (run),
    .cisn     (cur_isn),
    .value    (cnt_value),
    .addr     (cnt_addr),
    .pisn     (cnt_pisn),
    .ld       (ld),
    .e0       (e0),
    .e1_v     (e1_v),
    .e1       (e1)
  );

  irle_out_stage #(.ENT_W(ENT_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (ld),
    .e0        (e0),
    .e1_v      (e1_v),
    .e1        (e1),
    .log_ready (log_ready),
    .log_valid (log_valid),
    .log_entry (log_entry),
    .idle      (idle)
  );

  // R4
  no_empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && (ent_kind_e'(log_entry[ENT_W-1 -: 2]) == ENT_BLOCK))
      |-> (log_entry[CNT_W-1:0] != '0));

  // R6
  isn_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end |=> (cur_isn == $past(cur_isn) + 1'b1));

  // R11
  nop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_nop |=> !log_valid);

  // R3
  reorder_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rl || do_rs) |=> log_valid);

endmodule

// File: tb/interval_log_encoder_tb_top.sv
module interval_log_encoder_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int CW = 4;
  localparam int PW = AW + DW + IW;
  localparam int EW = 2 + PW;
  localparam int VW = 1 + 2 + DW + AW + IW;
  localparam int NV = 17;

  // vector layout: {end, class, value, addr, pisn}
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {1'b0, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b0, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b0, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b0, 2'd1, 32'hAAAA_0001, 16'h0,    4'h0},
    {1'b0, 2'd1, 32'h0000_0002, 16'h0,    4'h0},
    {1'b0, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b0, 2'd2, 32'hDEAD_BEEF, 16'h1234, 4'h0},
    {1'b1, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b1, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b0, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b0, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b0, 2'd2, 32'h0BAD_F00D, 16'hBEEF, 4'hF},
    {1'b0, 2'd3, 32'h1111_1111, 16'h2222, 4'h3},
    {1'b0, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b1, 2'd0, 32'h0,         16'h0,    4'h0},
    {1'b0, 2'd2, 32'hCAFE_0000, 16'h00AA, 4'h1},
    {1'b1, 2'd0, 32'h0,         16'h0,    4'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_valid = 1'b0;
  logic [1:0]    cnt_class = '0;
  logic [DW-1:0] cnt_value = '0;
  logic [AW-1:0] cnt_addr = '0;
  logic [IW-1:0] cnt_pisn = '0;
  logic          iend_req = 1'b0;
  logic          log_ready = 1'b1;
  logic          in_ready, log_valid;
  logic [EW-1:0] log_entry;
  logic [IW-1:0] cur_isn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [EW-1:0] exp_q[$];
  string         tag_q[$];
  logic [CW-1:0] m_run = '0;
  logic [IW-1:0] m_isn = '0;

  always #4 clk = ~clk;

  interval_log_encoder #(.ADDR_W(AW), .DATA_W(DW), .ISN_W(IW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_valid(cnt_valid), .cnt_class(cnt_class),
    .cnt_value(cnt_value), .cnt_addr(cnt_addr), .cnt_pisn(cnt_pisn),
    .iend_req(iend_req), .in_ready(in_ready), .log_valid(log_valid),
    .log_ready(log_ready), .log_entry(log_entry), .cur_isn(cur_isn)
  );

  function automatic logic [EW-1:0] mk(logic [1:0] kind, logic [PW-1:0] pay);
    logic [EW-1:0] r;
    r = '0;
    r[PW-1:0] = pay;
    r[EW-1:EW-2] = kind;
    return r;
  endfunction

  function automatic logic [EW-1:0] mk_store(logic [AW-1:0] a, logic [DW-1:0] d, logic [IW-1:0] o);
    logic [PW-1:0] p;
    p = (PW'(a) << (DW + IW)) | (PW'(d) << IW) | PW'(o);
    return mk(2'd2, p);
  endfunction

  task automatic check(bit ok, string req, logic [EW-1:0] act, logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [EW-1:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic flush_run(string t);
    if (m_run != 0) push(mk(2'd0, PW'(m_run)), {t, " R2 R4"});
    m_run = '0;
  endtask

  // independent expectation model
  task automatic model(bit e, logic [1:0] c, logic [DW-1:0] v, logic [AW-1:0] a,
                       logic [IW-1:0] p, string t);
    if (e) begin
      flush_run(t);
      push(mk(2'd3, PW'(m_isn)), {t, " R6"});
      m_isn = m_isn + 1'b1;
    end else begin
      case (c)
        2'd0: begin
          m_run = m_run + 1'b1;
          if (m_run == 4'd15) begin
            push(mk(2'd0, PW'(4'd15)), {t, " R10"});
            m_run = '0;
          end
        end
        2'd1: begin
          flush_run(t);
          push(mk(2'd1, PW'(v)), {t, " R3 R7"});
        end
        2'd2: begin
          flush_run(t);
          push(mk_store(a, v, m_isn - p), {t, " R5 R7"});
        end
        default: ;
      endcase
    end
  endtask

  task automatic send(bit e, logic [1:0] c, logic [DW-1:0] v, logic [AW-1:0] a,
                      logic [IW-1:0] p, string t);
    model(e, c, v, a, p, t);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    iend_req  = e;
    cnt_valid = !e;
    cnt_class = c;
    cnt_value = v;
    cnt_addr  = a;
    cnt_pisn  = p;
    @(negedge clk);
    iend_req  = 1'b0;
    cnt_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 40; k++) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // output monitor, samples between edges
  always begin
    @(negedge clk);
    #2;
    if (rst_n && log_valid && log_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected entry", log_entry, '0);
      end else begin
        logic [EW-1:0] ex;
        string tg;
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(log_entry === ex, {tg, " R12"}, log_entry, ex);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  initial begin
    logic [EW-1:0] held;
    // R1 reset state
    for (int k = 0; k < 4; k++) @(negedge clk);
    check(log_valid == 1'b0, "R1 log_valid", EW'(log_valid), '0);
    check(in_ready == 1'b1, "R1 in_ready", EW'(in_ready), EW'(1));
    check(cur_isn == '0, "R1 cur_isn", EW'(cur_isn), '0);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] vv;
      vv = VEC[i];
      send(vv[VW-1], vv[VW-2 -: 2], vv[DW+AW+IW-1 -: DW], vv[AW+IW-1 -: AW], vv[IW-1:0], "table");
    end
    drain();
    check(exp_q.size() == 0, "R4 R12 entry count after table", EW'(exp_q.size()), '0);
    check(cur_isn == m_isn, "R6 interval number", EW'(cur_isn), EW'(m_isn));

    // R11: class 3 with a pending run leaves the run intact
    send(1'b0, 2'd0, '0, '0, '0, "nop");
    send(1'b0, 2'd0, '0, '0, '0, "nop");
    send(1'b0, 2'd3, 32'h7777_7777, 16'h7777, 4'h7, "nop");
    check(log_valid == 1'b0, "R11 no entry", EW'(log_valid), '0);
    send(1'b1, 2'd0, '0, '0, '0, "R11 run kept");
    drain();

    // R10 limit flush and R8 hold under backpressure
    log_ready = 1'b0;
    for (int k = 0; k < 15; k++) send(1'b0, 2'd0, '0, '0, '0, "limit");
    check(log_valid == 1'b1, "R10 flush valid", EW'(log_valid), EW'(1));
    check(log_entry == mk(2'd0, PW'(4'd15)), "R10 flush entry", log_entry, mk(2'd0, PW'(4'd15)));
    check(in_ready == 1'b0, "R8 in_ready low while waiting", EW'(in_ready), '0);
    held = log_entry;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(log_valid == 1'b1 && log_entry == held, "R8 held entry", log_entry, held);
    end
    log_ready = 1'b1;
    drain();
    send(1'b0, 2'd0, '0, '0, '0, "limit");
    send(1'b0, 2'd0, '0, '0, '0, "limit");
    send(1'b1, 2'd0, '0, '0, '0, "limit");
    drain();

    // R9 simultaneous end request and count
    send(1'b0, 2'd0, '0, '0, '0, "R9");
    model(1'b1, 2'd0, '0, '0, '0, "R9");
    model(1'b0, 2'd2, 32'h5555_AAAA, 16'h0F0F, cur_isn, "R9");
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    iend_req  = 1'b1;
    cnt_valid = 1'b1;
    cnt_class = 2'd2;
    cnt_value = 32'h5555_AAAA;
    cnt_addr  = 16'h0F0F;
    cnt_pisn  = cur_isn;
    @(negedge clk);
    iend_req = 1'b0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    cnt_valid = 1'b0;
    drain();
    check(exp_q.size() == 0, "R9 R12 entry count", EW'(exp_q.size()), '0);
    check(cur_isn == m_isn, "R9 interval number", EW'(cur_isn), EW'(m_isn));
    report();
  end

endmodule